// File: doc/BRIEF.md
# Fly-by DMA Controller with Cycle-Steal to Burst Switch

This block moves a programmed block of words from an IO device into memory over a memory bus that it shares with a CPU. Each word is a single fly-by transfer. The device drives its data onto the bus while the controller presents the memory address. The controller pulses the memory write strobe in the final cycle of the transfer. No word is ever held inside the controller. One transfer lasts as many cycles as the slower of the two programmable access times.

A run begins in cycle-stealing mode. In this mode the controller takes the bus for one word only at a CPU state boundary, then gives the bus back. Once a programmed number of words has been moved, the controller switches to burst mode. It then keeps the bus without releasing it until the last word is written.

The CPU reports its current instruction-cycle state, and a pulse in the last cycle of each state. While the controller owns the bus, the CPU is stalled only in the two states that need memory. In the other states it continues to run.

The device side works as a valid/ready pair. `io_req` says that a word is available. `io_ack` is high for every cycle in which the word is being taken. The device must hold its word, and keep `io_req` high, until it has seen the write-strobe cycle. A low `io_req` applies back-pressure: no transfer starts and the bus is not taken.

Top module: `flyby_dma`

## Requirements
- R1: After reset, `cpu_grant` is 1, and `cpu_stall`, `io_ack`, `mem_we` and `done` are all 0.
- R2: The configuration inputs are captured on `cfg_load` only while the controller is idle. A `cfg_load` pulse during a run changes neither the word count nor the addresses of that run.
- R3: In cycle-stealing mode, and for the first word of a burst, the bus is taken (`cpu_grant` falls) only in the cycle after one in which both `cpu_phase_end` and `io_req` were 1.
- R4: A transfer keeps `io_ack` high for max(mem time, io time) consecutive cycles, with a minimum of 1. `mem_we` is high only in the last of those cycles.
- R5: The first word is written at the configured start address. Each later word is written at the previous address plus 1.
- R6: In cycle-stealing mode, `cpu_grant` returns in the cycle after the last cycle of a word that is not the final word.
- R7: After the threshold number of words, the controller holds the bus. `cpu_grant` stays 0 from the threshold word through the done cycle, and the next word starts one cycle after the previous one ends, with no wait for a CPU boundary.
- R8: `cpu_stall` is 1 exactly when `cpu_grant` is 0 and `cpu_phase` is fetch (code 0) or operand fetch (code 2). For decode (1), execute (3) and interrupt (4), `cpu_stall` stays 0.
- R9: `done` is a one-cycle pulse in the cycle after the final write. `cpu_grant` is 1 in the cycle after `done`.
- R10: A threshold of 0 runs the whole block as a burst. A threshold greater than or equal to the word count runs every word as a single stolen cycle.
- R11: Starting with a word count of 0 raises `done` in the next cycle, and no transfer or bus grab takes place.
- R12: While `io_req` is 0, no transfer starts and the bus is not taken. The run continues when `io_req` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture the configuration (effective only while idle) |
| cfg_words | input | CNT_W | Number of words in the block |
| cfg_thresh | input | CNT_W | Number of stolen-cycle words moved before switching to burst |
| cfg_addr | input | ADDR_W | First memory address |
| cfg_mem_t | input | TIME_W | Memory access time, in cycles |
| cfg_io_t | input | TIME_W | IO access time, in cycles |
| start | input | 1 | Begin a run (effective only while idle) |
| cpu_phase | input | 3 | CPU state: 0 fetch, 1 decode, 2 operand fetch, 3 execute, 4 interrupt |
| cpu_phase_end | input | 1 | High in the last cycle of the current CPU state |
| io_req | input | 1 | Device has a word ready (valid) |
| io_ack | output | 1 | Word being taken (ready), high for the whole transfer |
| mem_addr | output | ADDR_W | Memory address of the current word |
| mem_we | output | 1 | Memory write strobe |
| cpu_grant | output | 1 | CPU owns the memory bus |
| cpu_stall | output | 1 | CPU must hold its current state |
| done | output | 1 | One-cycle pulse at the end of the block |

## Verification
The block is driven by a CPU model that moves through its five states and respects the stall. Five runs are made:
- An all-stolen run with a threshold above the word count. Each bus ownership lasts exactly one transfer, which separates per-word release from holding the bus.
- A run that switches after two words. It shows the change from separate short grant-low windows to one long hold.
- A zero-threshold run. It must form a single hold from the first word.
- A zero-length run. It must finish without touching the bus.
- A run with `io_req` held low. During this run a reconfiguration is attempted. This shows that back-pressure stops the bus grab, and that a configuration load during a run has no effect on the words written.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

  localparam logic [2:0] PH_FETCH   = 3'd0;
  localparam logic [2:0] PH_DECODE  = 3'd1;
  localparam logic [2:0] PH_OPFETCH = 3'd2;
  localparam logic [2:0] PH_EXEC    = 3'd3;
  localparam logic [2:0] PH_INTR    = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MOVE,
    ST_DONE
  } dma_state_e;

  function automatic logic phase_uses_bus(input logic [2:0] ph);
    return (ph == PH_FETCH) || (ph == PH_OPFETCH);
  endfunction

endpackage

// File: rtl/flyby_dma_cfg.sv
module flyby_dma_cfg #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  words_in,
  input  logic [CNT_W-1:0]  thresh_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [TIME_W-1:0] mem_t_in,
  input  logic [TIME_W-1:0] io_t_in,
  output logic [CNT_W-1:0]  words,
  output logic [CNT_W-1:0]  thresh,
  output logic [ADDR_W-1:0] base_addr,
  output logic [TIME_W-1:0] xfer_len
);

  logic [TIME_W-1:0] slow_t;
  logic [TIME_W-1:0] len_in;

  // fly-by: one transfer lasts as long as the slower side, never zero
  assign slow_t = (mem_t_in > io_t_in) ? mem_t_in : io_t_in;
  assign len_in = (slow_t == '0) ? TIME_W'(1) : slow_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words     <= '0;
      thresh    <= '0;
      base_addr <= '0;
      xfer_len  <= TIME_W'(1);
    end else if (wr_en) begin
      words     <= words_in;
      thresh    <= thresh_in;
      base_addr <= addr_in;
      xfer_len  <= len_in;
    end
  end

endmodule

// File: rtl/flyby_dma_cnt.sv
module flyby_dma_cnt #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [CNT_W-1:0]  init_words,
  input  logic [CNT_W-1:0]  init_thresh,
  input  logic [ADDR_W-1:0] init_addr,
  output logic [CNT_W-1:0]  words_left,
  output logic [CNT_W-1:0]  steal_left,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_left <= '0;
      steal_left <= '0;
      addr       <= '0;
    end else if (load) begin
      words_left <= init_words;
      steal_left <= init_thresh;
      addr       <= init_addr;
    end else if (step) begin
      words_left <= words_left - CNT_W'(1);
      addr       <= addr + ADDR_W'(1);
      if (steal_left != '0) steal_left <= steal_left - CNT_W'(1);
    end
  end

endmodule

// File: rtl/flyby_dma_timer.sv
module flyby_dma_timer #(
  parameter int TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [TIME_W-1:0] len,
  output logic              last
);

  logic [TIME_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= len;
    else if (run && left_q != '0) left_q <= left_q - TIME_W'(1);
  end

  assign last = run && (left_q == TIME_W'(1));

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CNT_W-1:0]  cfg_words,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [TIME_W-1:0] cfg_mem_t,
  input  logic [TIME_W-1:0] cfg_io_t,
  input  logic              start,
  input  logic [2:0]        cpu_phase,
  input  logic              cpu_phase_end,
  input  logic              io_req,
  output logic              io_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              cpu_grant,
  output logic              cpu_stall,
  output logic              done
);

  dma_state_e state_q, state_d;
  logic own_q, own_d;

  logic [CNT_W-1:0]  words_r, thresh_r, words_left, steal_left;
  logic [ADDR_W-1:0] base_r, addr_q;
  logic [TIME_W-1:0] len_r;
  logic cfg_wr, cnt_load, cnt_step, tmr_load, tmr_last;
  logic in_burst, grab, final_word, keep_bus;

  assign cfg_wr = cfg_load && (state_q == ST_IDLE);

  flyby_dma_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .words_in  (cfg_words),
    .thresh_in (cfg_thresh),
    .addr_in   (cfg_addr),
    .mem_t_in  (cfg_mem_t),
    .io_t_in   (cfg_io_t),
    .words     (words_r),
    .thresh    (thresh_r),
    .base_addr (base_r),
    .xfer_len  (len_r)
  );

  flyby_dma_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (cnt_load),
    .step        (cnt_step),
    .init_words  (words_r),
    .init_thresh (thresh_r),
    .init_addr   (base_r),
    .words_left  (words_left),
    .steal_left  (steal_left),
    .addr        (addr_q)
  );

  flyby_dma_timer #(.TIME_W(TIME_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .run   (state_q == ST_MOVE),
    .len   (len_r),
    .last  (tmr_last)
  );

  // burst once the stolen-cycle allowance is used up
  assign in_burst   = (steal_left == '0);
  // a held bus in burst needs no boundary; otherwise wait for one
  assign grab       = io_req && ((in_burst && own_q) || cpu_phase_end);
  assign final_word = (words_left == CNT_W'(1));
  // keep the bus if already in burst or this word completes the allowance
  assign keep_bus   = (steal_left <= CNT_W'(1));

  always_comb begin
    state_d  = state_q;
    own_d    = own_q;
    cnt_load = 1'b0;
    cnt_step = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cnt_load = 1'b1;
          state_d  = (words_r == '0) ? ST_DONE : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (grab) begin
          tmr_load = 1'b1;
          own_d    = 1'b1;
          state_d  = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (tmr_last) begin
          cnt_step = 1'b1;
          if (final_word) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_WAIT;
            own_d   = keep_bus;
          end
        end
      end
      ST_DONE: begin
        own_d   = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      own_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      own_q   <= own_d;
    end
  end

  assign io_ack    = (state_q == ST_MOVE);
  assign mem_we    = tmr_last;
  assign mem_addr  = addr_q;
  assign cpu_grant = !own_q;
  assign cpu_stall = own_q && phase_uses_bus(cpu_phase);
  assign done      = (state_q == ST_DONE);

endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cpu_phase,
  input logic              cpu_phase_end,
  input logic              io_req,
  input logic              io_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              cpu_grant,
  input logic              cpu_stall,
  input logic              done
);

  p_strobe_inside_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> io_ack);

  p_ack_only_when_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_ack |-> !cpu_grant);

  p_grab_after_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_grant) |-> $past(cpu_phase_end && io_req));

  p_addr_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  p_stall_needs_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (!cpu_grant && (cpu_phase == PH_FETCH || cpu_phase == PH_OPFETCH)));

  p_free_states_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_phase == PH_DECODE || cpu_phase == PH_EXEC || cpu_phase == PH_INTR) |-> !cpu_stall);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_grant_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cpu_grant);

endmodule

bind flyby_dma flyby_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_phase     (cpu_phase),
  .cpu_phase_end (cpu_phase_end),
  .io_req        (io_req),
  .io_ack        (io_ack),
  .mem_addr      (mem_addr),
  .mem_we        (mem_we),
  .cpu_grant     (cpu_grant),
  .cpu_stall     (cpu_stall),
  .done          (done)
);

// File: tb/flyby_dma_test.sv
`timescale 1ns/1ps
module flyby_dma_test;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [CW-1:0] cfg_words = '0, cfg_thresh = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [TW-1:0] cfg_mem_t = '0, cfg_io_t = '0;
  logic start = 1'b0;
  logic [2:0] cpu_phase = 3'd0;
  logic cpu_phase_end;
  logic io_req = 1'b0;
  logic io_ack, mem_we, cpu_grant, cpu_stall, done;
  logic [AW-1:0] mem_addr;
  int ph_cnt = 2;

  always #10 clk = ~clk;

  assign cpu_phase_end = rst_n && (ph_cnt == 1) && !cpu_stall;

  flyby_dma #(.ADDR_W(AW), .CNT_W(CW), .TIME_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_words(cfg_words),
    .cfg_thresh(cfg_thresh), .cfg_addr(cfg_addr), .cfg_mem_t(cfg_mem_t),
    .cfg_io_t(cfg_io_t), .start(start), .cpu_phase(cpu_phase),
    .cpu_phase_end(cpu_phase_end), .io_req(io_req), .io_ack(io_ack),
    .mem_addr(mem_addr), .mem_we(mem_we), .cpu_grant(cpu_grant),
    .cpu_stall(cpu_stall), .done(done)
  );

  int checks = 0;
  int errors = 0;

  // CPU model: two cycles per state, holds while stalled
  initial begin
    logic pe;
    forever begin
      @(negedge clk);
      pe = cpu_phase_end;
      @(posedge clk);
      #1;
      if (!rst_n) begin
        cpu_phase = 3'd0;
        ph_cnt = 2;
      end else if (pe) begin
        cpu_phase = (cpu_phase == 3'd4) ? 3'd0 : cpu_phase + 3'd1;
        ph_cnt = 2;
      end else if (!cpu_stall && ph_cnt > 1) begin
        ph_cnt = ph_cnt - 1;
      end
    end
  end

  // monitor
  int we_cnt, ack_run, ack_bad, exp_len, nruns, low_len, stall_bad, stall_seen;
  int fall_bad, done_cnt, done_bad;
  int runs [8];
  logic [AW-1:0] we_addr [16];
  logic g_q = 1'b1, pe_q = 1'b0, req_q = 1'b0, done_q = 1'b0, ack_q = 1'b0, we_q = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_stall !== (!cpu_grant && (cpu_phase == 3'd0 || cpu_phase == 3'd2))) stall_bad++;
      if (cpu_stall) stall_seen++;
      if (g_q && !cpu_grant && !(pe_q && req_q)) fall_bad++;
      if (done_q && (done || !cpu_grant)) done_bad++;
      if (done) done_cnt++;
      if (io_ack) ack_run++; else ack_run = 0;
      if (mem_we) begin
        if (ack_run != exp_len) ack_bad++;
        if (we_cnt < 16) we_addr[we_cnt] = mem_addr;
        we_cnt++;
      end
      if (ack_q && !io_ack && !we_q) ack_bad++;
      if (!cpu_grant) low_len++;
      else if (low_len > 0) begin
        if (nruns < 8) runs[nruns] = low_len;
        nruns++;
        low_len = 0;
      end
      g_q = cpu_grant; pe_q = cpu_phase_end; req_q = io_req;
      done_q = done; ack_q = io_ack; we_q = mem_we;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic clear_stats(input int len);
    we_cnt = 0; ack_run = 0; ack_bad = 0; exp_len = len; nruns = 0;
    low_len = 0; stall_seen = 0; fall_bad = 0; done_cnt = 0;
  endtask

  task automatic configure(input int w, input int th, input int a, input int mt, input int it);
    @(posedge clk); #2;
    cfg_words = CW'(w); cfg_thresh = CW'(th); cfg_addr = AW'(a);
    cfg_mem_t = TW'(mt); cfg_io_t = TW'(it); cfg_load = 1'b1;
    @(posedge clk); #2;
    cfg_load = 1'b0;
  endtask

  task automatic launch();
    @(posedge clk); #2; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int seen = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    chk({tag, " done reached"}, seen, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 grant in reset", int'(cpu_grant), 1);
    chk("R1 stall/ack/we/done in reset", int'(cpu_stall | io_ack | mem_we | done), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 grant after reset", int'(cpu_grant), 1);
    chk("R1 outputs quiet after reset", int'(cpu_stall | io_ack | mem_we | done), 0);
  endtask

  task automatic t_all_steal();
    configure(3, 5, 'h100, 2, 3);
    clear_stats(3);
    io_req = 1'b1;
    launch();
    wait_done("R6");
    chk("R4 words written", we_cnt, 3);
    chk("R4 ack length and strobe placement", ack_bad, 0);
    chk("R5 first address", int'(we_addr[0]), 'h100);
    chk("R5 third address", int'(we_addr[2]), 'h102);
    chk("R10 R6 separate grabs", nruns, 3);
    chk("R6 first word hold", runs[0], 3);
    chk("R6 second word hold", runs[1], 3);
    chk("R9 final hold incl done", runs[2], 4);
    chk("R9 one done pulse", done_cnt, 1);
    chk("R3 grabs at boundary", fall_bad, 0);
    io_req = 1'b0;
  endtask

  task automatic t_switch();
    configure(5, 2, 'h200, 1, 1);
    clear_stats(1);
    io_req = 1'b1;
    launch();
    wait_done("R7");
    chk("R7 words written", we_cnt, 5);
    chk("R7 two holds", nruns, 2);
    chk("R7 stolen word hold", runs[0], 1);
    chk("R7 burst hold", runs[1], 8);
    chk("R5 last address", int'(we_addr[4]), 'h204);
    chk("R8 stall occurred in burst", int'(stall_seen > 0), 1);
    chk("R3 grabs at boundary", fall_bad, 0);
    io_req = 1'b0;
  endtask

  task automatic t_zero_thresh();
    configure(3, 0, 'h300, 2, 1);
    clear_stats(2);
    io_req = 1'b1;
    launch();
    wait_done("R10");
    chk("R10 burst single hold", nruns, 1);
    chk("R10 burst hold length", runs[0], 9);
    chk("R10 words written", we_cnt, 3);
    chk("R4 ack length", ack_bad, 0);
    io_req = 1'b0;
  endtask

  task automatic t_zero_words();
    configure(0, 1, 'h10, 1, 1);
    clear_stats(1);
    io_req = 1'b1;
    @(posedge clk); #2; start = 1'b1;
    @(negedge clk);
    chk("R11 done not yet", int'(done), 0);
    @(posedge clk); #2; start = 1'b0;
    @(negedge clk);
    chk("R11 done next cycle", int'(done), 1);
    repeat (4) @(negedge clk);
    chk("R11 no writes", we_cnt, 0);
    chk("R11 bus never taken", nruns + low_len, 0);
    io_req = 1'b0;
  endtask

  task automatic t_backpressure();
    configure(2, 2, 'h400, 1, 2);
    clear_stats(2);
    io_req = 1'b0;
    launch();
    repeat (20) @(negedge clk);
    chk("R12 no write while io_req low", we_cnt, 0);
    chk("R12 bus untouched while io_req low", nruns + low_len, 0);
    configure(7, 0, 'h500, 1, 1);
    @(posedge clk); #2; io_req = 1'b1;
    wait_done("R12");
    chk("R2 word count kept", we_cnt, 2);
    chk("R2 start address kept", int'(we_addr[0]), 'h400);
    chk("R5 second address", int'(we_addr[1]), 'h401);
    chk("R12 two stolen holds", nruns, 2);
    chk("R6 stolen hold", runs[0], 2);
    io_req = 1'b0;
  endtask

  initial begin
    stall_bad = 0; done_bad = 0;
    clear_stats(1);
    t_reset();
    t_all_steal();
    t_switch();
    t_zero_thresh();
    t_zero_words();
    t_backpressure();
    chk("R8 stall matches bus need", stall_bad, 0);
    chk("R9 done pulse and grant return", done_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule